// File: doc/BRIEF.md
# Two-Wire Master Clock and Start Controller

This block is the master-side timing core of a two-wire serial bus. It turns the system clock into the bus clock through a programmable half-period counter, puts a START on the bus on request, and runs one bus-clock pulse each time software hands control back. Byte shifting, address matching and arbitration are handled elsewhere.

Every finished job sets a completion flag. While that flag is set, the bus clock is held low. This stalls the bus until software has dealt with the job. Software clears the flag by writing a one to its clear bit, and that write starts the next clock pulse.

A START request is only acted on when the bus is idle. A bus monitor marks the bus busy on every START it sees and idle on every STOP. A request made while the bus is busy is held until the next STOP, and the START is then issued. The bus lines are modelled open-drain: a high `*_oe` pulls the wire low, and `*_in` is the wire level as sensed.

Top module: `twm_sclgen`

## Requirements
- R1: After reset the divider reads 0, the block is disabled, and the completion flag, pending request, bus-busy and interrupt are 0. Neither line is pulled low.
- R2: A START holds SDA low with SCL released for exactly 8 + div system clocks. It then pulls SCL low.
- R3: After the flag is cleared, SCL is pulled low for 8 + div clocks and then released for 8 + div clocks. One bit period is therefore 16 + 2 × div clocks.
- R4: The completion flag sets when the START phase ends and when each high phase ends. While the flag is set, SCL stays pulled low for as long as software waits.
- R5: The flag clears only on a control write with bit 3 = 1. A control write with bit 3 = 0 leaves it set, and so does a pending interrupt.
- R6: A write that clears the flag starts the SCL low phase on the next clock.
- R7: `irq` is 1 exactly when the flag, the interrupt-enable bit (control bit 1) and `gie` are all 1.
- R8: A control write with enable (bit 0) and start (bit 2) both 1, made while the bus is idle, raises the pending request one clock after the write. SDA is pulled low on the clock after that.
- R9: The bus monitor sets busy one clock after SDA falls while SCL is high. It clears busy one clock after SDA rises while SCL is high.
- R10: A START request made while the bus is busy pulls no line until a STOP is seen. The START then begins one clock after busy clears.
- R11: During the high phase, the counter advances only on clocks where SCL is sensed high. A slave holding SCL low therefore lengthens the high phase by the time it holds the line.
- R12: With enable 0, a start bit in a control write is ignored. Writing enable 0 returns the block to idle within two clocks, releases both lines and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | 8 | New divider value |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control bits. Bit 0 is enable and bit 1 is interrupt enable; both are stored. Bit 2 is a start pulse and bit 3 is a flag-clear pulse |
| gie | input | 1 | Global interrupt enable |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| div_o | output | 8 | Divider register readback |
| done_o | output | 1 | Completion flag |
| busy_o | output | 1 | Bus busy |
| pend_o | output | 1 | START request pending |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- SCL is held low whenever the flag is set.
- The flag only falls after a clear write or a disable.
- SDA is never pulled low to start while the bus monitor reports busy.
- The high-phase counter freezes while SCL is sensed low.
- The interrupt is raised only while SCL is stretched.

The bench scenarios show the exact lengths of the START, low and high phases for several divider values. They also cover how long the slave-side stretch adds to the high phase, the gating of the interrupt, and that a START deferred on a busy bus is issued one clock after the STOP.

// File: rtl/twm_sclgen.sv
module twm_sclgen #(
  parameter int DIVW  = 8,
  parameter int BASEH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            div_we,
  input  logic [DIVW-1:0] div_wdata,
  input  logic            ctl_we,
  input  logic [3:0]      ctl_wdata,
  input  logic            gie,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic [DIVW-1:0] div_o,
  output logic            done_o,
  output logic            busy_o,
  output logic            pend_o,
  output logic            irq
);
  localparam int CW = DIVW + 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_LOW, S_HIGH} st_t;

  st_t            st;
  logic [DIVW-1:0] div_q;
  logic [CW-1:0]   cnt;
  logic            en_q, ie_q, req_q, done_q, busy_q, scl_q, sda_q;

  wire [CW-1:0] half_m1   = CW'(BASEH - 1) + CW'(div_q);
  wire          hit       = (cnt == half_m1);
  wire          clr_wr    = ctl_we && ctl_wdata[3];
  wire          bus_start = scl_q && scl_in && sda_q && !sda_in;
  wire          bus_stop  = scl_q && scl_in && !sda_q && sda_in;

  assign scl_oe = (st == S_HOLD) || (st == S_LOW);
  assign sda_oe = (st != S_IDLE);
  assign div_o  = div_q;
  assign done_o = done_q;
  assign busy_o = busy_q;
  assign pend_o = req_q;
  assign irq    = done_q && ie_q && gie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div_q <= '0;
      cnt <= '0;
      en_q <= 1'b0;
      ie_q <= 1'b0;
      req_q <= 1'b0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (bus_start) busy_q <= 1'b1;
      else if (bus_stop) busy_q <= 1'b0;
      if (div_we) div_q <= div_wdata;
      if (ctl_we) begin
        en_q <= ctl_wdata[0];
        ie_q <= ctl_wdata[1];
      end
      if (!en_q) begin
        st <= S_IDLE;
        cnt <= '0;
        done_q <= 1'b0;
        req_q <= ctl_we && ctl_wdata[0] && ctl_wdata[2];
      end else begin
        if (ctl_we && ctl_wdata[0] && ctl_wdata[2]) req_q <= 1'b1;
        if (clr_wr) done_q <= 1'b0;
        case (st)
          S_IDLE:
            if (req_q && !busy_q) begin
              st <= S_START;
              cnt <= '0;
              req_q <= 1'b0;
            end
          S_START:
            if (hit) begin
              st <= S_HOLD;
              done_q <= 1'b1;
            end else cnt <= cnt + 1'b1;
          S_HOLD:
            if (clr_wr) begin
              st <= S_LOW;
              cnt <= '0;
            end
          S_LOW:
            if (hit) begin
              st <= S_HIGH;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          S_HIGH:
            if (scl_in) begin
              if (hit) begin
                st <= S_HOLD;
                done_q <= 1'b1;
              end else cnt <= cnt + 1'b1;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R4
  flag_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> scl_oe);
  // R5
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(clr_wr || !en_q));
  // R7
  irq_while_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (scl_oe && gie));
  // R10
  start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!busy_q));
  // R11
  high_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && en_q && !scl_in) |=> $stable(cnt));
  // R12
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_twm_sclgen.sv
module tb_twm_sclgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_we = 1'b0;
  logic [7:0] div_wdata = '0;
  logic ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic gie = 1'b0;
  logic ext_scl_low = 1'b0;
  logic ext_sda_low = 1'b0;
  logic scl_oe, sda_oe, done_o, busy_o, pend_o, irq;
  logic [7:0] div_o;
  wire scl_in = !(scl_oe || ext_scl_low);
  wire sda_in = !(sda_oe || ext_sda_low);
  int tests = 0;
  int fails = 0;

  always #5 clk = !clk;

  twm_sclgen dut (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .gie(gie),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .div_o(div_o), .done_o(done_o), .busy_o(busy_o), .pend_o(pend_o), .irq(irq)
  );

  function automatic int half_exp(input int d);
    return 8 + d;
  endfunction

  function automatic int high_exp(input int d, input int k);
    return (k == 0) ? half_exp(d) : half_exp(d) + k - 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_scl_low = 1'b0;
    ext_sda_low = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_div(input logic [7:0] v);
    div_we = 1'b1;
    div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic run_bit(input int d, input int w, input int k, input bit ie, input bit g);
    int n;
    logic [3:0] base;
    base = {2'b00, ie, 1'b1};
    do_reset();
    gie = g;
    wr_div(8'(d));
    chk(div_o == 8'(d), "R1 divider readback", div_o, d);
    wr_ctl(base | 4'b0100);
    chk(pend_o && !sda_oe, "R8 pending before start", {pend_o, sda_oe}, 2);
    @(negedge clk);
    chk(sda_oe && !scl_oe, "R8 start drives sda", {sda_oe, scl_oe}, 2);
    n = 0;
    while (sda_oe && !scl_oe && n < 600) begin
      n++;
      @(negedge clk);
    end
    chk(n == half_exp(d), "R2 start phase length", n, half_exp(d));
    chk(done_o && scl_oe, "R4 flag after start", {done_o, scl_oe}, 3);
    chk(irq == (ie && g), "R7 irq gating", irq, ie && g);
    chk(busy_o, "R9 own start seen busy", busy_o, 1);
    n = 0;
    for (int i = 0; i < w; i++) begin
      if (scl_oe && done_o) n++;
      @(negedge clk);
    end
    chk(n == w, "R4 stretch while flag set", n, w);
    wr_ctl(base);
    chk(done_o && scl_oe, "R5 write without clear keeps flag", done_o, 1);
    ext_scl_low = (k != 0);
    wr_ctl(base | 4'b1000);
    chk(!done_o && !irq, "R6 flag cleared", done_o, 0);
    n = 0;
    while (scl_oe && n < 600) begin
      n++;
      @(negedge clk);
    end
    chk(n == half_exp(d), "R3 low phase length", n, half_exp(d));
    n = 0;
    while (!scl_oe && sda_oe && n < 1200) begin
      n++;
      if (n == k) ext_scl_low = 1'b0;
      @(negedge clk);
    end
    if (k == 0) chk(n == high_exp(d, k), "R3 high phase length", n, high_exp(d, k));
    else chk(n == high_exp(d, k), "R11 stretched high phase", n, high_exp(d, k));
    chk(done_o && scl_oe, "R4 flag after bit", {done_o, scl_oe}, 3);
    wr_ctl(4'b0000);
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !done_o, "R12 disable releases", {scl_oe, sda_oe, done_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    chk(div_o == 0 && !done_o && !pend_o && !busy_o && !irq && !scl_oe && !sda_oe,
        "R1 reset state", {div_o, done_o, pend_o, busy_o, irq, scl_oe, sda_oe}, 0);

    run_bit(0, 3, 0, 1'b1, 1'b1);
    run_bit(255, 2, 3, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      run_bit(int'($urandom % 40), 1 + int'($urandom % 10), int'($urandom % 4),
              1'($urandom), 1'($urandom));
    end

    do_reset();
    wr_ctl(4'b0100);
    chk(!pend_o, "R12 start ignored when disabled", pend_o, 0);
    repeat (5) @(negedge clk);
    chk(!sda_oe && !scl_oe, "R12 no drive when disabled", sda_oe, 0);

    do_reset();
    wr_div(8'd3);
    ext_sda_low = 1'b1;
    @(negedge clk);
    chk(busy_o, "R9 busy on bus start", busy_o, 1);
    wr_ctl(4'b0101);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sda_oe || !pend_o) chk(1'b0, "R10 start held while busy", sda_oe, 0);
    end
    chk(pend_o && !sda_oe, "R10 request still pending", pend_o, 1);
    ext_sda_low = 1'b0;
    @(negedge clk);
    chk(!busy_o && !sda_oe, "R9 busy cleared on stop", busy_o, 0);
    @(negedge clk);
    chk(sda_oe && !pend_o, "R10 start after stop", sda_oe, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule